// File: doc/BRIEF.md
# Interrupt Remapping Command Controller

This block is the global command and status front end of an interrupt-remapping unit. Software writes a 32-bit command word over a simple register bus. Each write can start up to three operations. The first turns remapping on or off. The second copies the staged table address into the active table pointer. The third sets the policy for compatibility-format interrupts. A separate status word holds only the operations that have completed. The command word itself always reads back as zero.

The block counts interrupt requests that are in flight from their accept to their completion. A change to the remap-enable state is held pending until no request is in flight and none is being accepted in the same cycle. Every interrupt is therefore handled wholly under one state. The block drives three outputs: the active enable, the active table pointer and a pass/block decision for compatibility-format interrupts. The last one depends on the extended interrupt mode input.

Top module: `irq_remap_cmd_ctrl`

## Requirements
- R1: After reset `remapEn` is 0, `activePtr` is 0, every status bit and the sticky error are 0, the in-flight count is 0 and `compatPass` is 1.
- R2: A read at the command offset (0x18) returns 0. A read at the status offset (0x1C) returns the enable status in bit 25, the pointer status in bit 24, the applied compatibility policy in bit 23 and the sticky error in bit 0, with all other bits 0. The table-address register sits at offset 0x20 and can be read and written.
- R3: A pending enable or disable is applied only at a clock edge where the in-flight count is 0 and `irqAccept` is low. `remapEn` and the enable status change together at that edge. When the block is idle this is the edge one cycle after the command write.
- R4: A command write issues an enable/disable request only when bit 25 differs from the current enable status. A write whose bit 25 equals the current status cancels any pending request.
- R5: A command write with bit 24 set copies the table-address register into `activePtr` at the write edge and sets the pointer status.
- R6: A command write with bit 24 clear leaves `activePtr` and the pointer status unchanged.
- R7: Bit 23 of every command write is stored as the applied compatibility policy at the write edge (0 = block, 1 = pass).
- R8: An enable request is rejected if the pointer status is 0 and bit 24 of the same write is also 0. A rejected request sets the sticky error, leaves remapping disabled, and is not made pending. Only reset clears the error. `remapEn` is never 1 while the pointer status is 0.
- R9: `compatPass` is 1 while remapping is off. While remapping is on it is 0 when `extMode` is 1, and otherwise it equals the applied policy.
- R10: The in-flight count goes up by one on `irqAccept` and down by one on `irqComplete`. It stays the same when both are high, and it neither drops below zero nor wraps above its maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| busWr | input | 1 | Register write strobe |
| busAddr | input | ADDR_W | Register byte offset |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Combinational read data for busAddr |
| irqAccept | input | 1 | An interrupt request is accepted this cycle |
| irqComplete | input | 1 | An in-flight interrupt request completes this cycle |
| extMode | input | 1 | Extended interrupt mode active |
| remapEn | output | 1 | Active remap-enable state |
| activePtr | output | PTR_W | Active remap table pointer |
| compatPass | output | 1 | 1 = let compatibility-format interrupts through, 0 = block them |

## Verification
Results fall into three timing groups:
- **At the write edge.** Pointer, policy and error results appear at the edge that takes the write. They are sampled at the falling edge right after it.
- **One edge later.** An enable or disable on an idle block takes effect at the following edge, so the bench waits exactly one more falling edge.
- **Under drain.** With requests in flight, the bench samples `remapEn` at the falling edge right after the last completion, where the old value must still hold. It samples again one edge later, where the new value must appear.

An accept in the cycle where the count is already zero must push the change back by a further completion. The bench checks this case at those same sampling points.

// File: rtl/irc_pkg.sv
package irc_pkg;
  localparam int DATA_W   = 32;
  localparam int CMD_OFF  = 'h18;
  localparam int STAT_OFF = 'h1C;
  localparam int TADR_OFF = 'h20;
  // Bit positions decoded by software on both command and status words
  localparam int EN_BIT   = 25;
  localparam int PTR_BIT  = 24;
  localparam int CFI_BIT  = 23;
  localparam int ERR_BIT  = 0;

  typedef struct packed {
    logic ptrLoad;
    logic cfiLoad;
    logic cfiVal;
  } dpStrobe_t;
endpackage

// File: rtl/irc_ctrl.sv
module irc_ctrl
  import irc_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdWr,
  input  logic      cmdEn,
  input  logic      cmdPtr,
  input  logic      cmdCfi,
  input  logic      ptrStat,
  input  logic      cntIdle,
  output dpStrobe_t strobe,
  output logic      remapEn,
  output logic      errFlag
);
  logic pending;
  logic ptrOk;

  assign ptrOk = ptrStat | cmdPtr;

  always_comb begin
    strobe.ptrLoad = cmdWr & cmdPtr;
    strobe.cfiLoad = cmdWr;
    strobe.cfiVal  = cmdCfi;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
      remapEn <= 1'b0;
      errFlag <= 1'b0;
    end else if (cmdWr) begin
      if (cmdEn == remapEn) begin
        pending <= 1'b0;
      end else if (cmdEn && !ptrOk) begin
        errFlag <= 1'b1;
        pending <= 1'b0;
      end else begin
        pending <= 1'b1;
      end
    end else if (pending && cntIdle) begin
      remapEn <= ~remapEn;
      pending <= 1'b0;
    end
  end
endmodule

// File: rtl/irc_datapath.sv
module irc_datapath
  import irc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  input  dpStrobe_t         strobe,
  input  logic              irqAccept,
  input  logic              irqComplete,
  input  logic              extMode,
  input  logic              remapEn,
  input  logic              errFlag,
  output logic [PTR_W-1:0]  activePtr,
  output logic [PTR_W-1:0]  tableAddr,
  output logic              ptrStat,
  output logic              cfiStat,
  output logic [CNT_W-1:0]  inflightCnt,
  output logic              cntIdle,
  output logic              compatPass
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic tadrWr;
  logic cntInc;
  logic cntDec;
  logic [DATA_W-1:0] statWord;

  assign tadrWr = busWr && (busAddr == ADDR_W'(TADR_OFF));
  assign cntInc = irqAccept && !irqComplete && (inflightCnt != CNT_MAX);
  assign cntDec = irqComplete && !irqAccept && (inflightCnt != '0);
  assign cntIdle = (inflightCnt == '0) && !irqAccept;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tableAddr <= '0;
    end else if (tadrWr) begin
      tableAddr <= busWdata[PTR_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activePtr <= '0;
      ptrStat   <= 1'b0;
    end else if (strobe.ptrLoad) begin
      activePtr <= tableAddr;
      ptrStat   <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfiStat <= 1'b0;
    end else if (strobe.cfiLoad) begin
      cfiStat <= strobe.cfiVal;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      inflightCnt <= '0;
    end else if (cntInc) begin
      inflightCnt <= inflightCnt + 1'b1;
    end else if (cntDec) begin
      inflightCnt <= inflightCnt - 1'b1;
    end
  end

  always_comb begin
    statWord          = '0;
    statWord[EN_BIT]  = remapEn;
    statWord[PTR_BIT] = ptrStat;
    statWord[CFI_BIT] = cfiStat;
    statWord[ERR_BIT] = errFlag;
  end

  always_comb begin
    if (busAddr == ADDR_W'(STAT_OFF)) begin
      busRdata = statWord;
    end else if (busAddr == ADDR_W'(TADR_OFF)) begin
      busRdata = DATA_W'(tableAddr);
    end else begin
      busRdata = '0;
    end
  end

  assign compatPass = !remapEn | (!extMode & cfiStat);
endmodule

// File: rtl/irq_remap_cmd_ctrl.sv
module irq_remap_cmd_ctrl
  import irc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              irqAccept,
  input  logic              irqComplete,
  input  logic              extMode,
  output logic              remapEn,
  output logic [PTR_W-1:0]  activePtr,
  output logic              compatPass
);
  dpStrobe_t        strobe;
  logic             cmdWr;
  logic             ptrStat;
  logic             cfiStat;
  logic             cntIdle;
  logic             errFlag;
  logic [PTR_W-1:0] tableAddr;
  logic [CNT_W-1:0] inflightCnt;

  assign cmdWr = busWr && (busAddr == ADDR_W'(CMD_OFF));

  irc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .cmdWr   (cmdWr),
    .cmdEn   (busWdata[EN_BIT]),
    .cmdPtr  (busWdata[PTR_BIT]),
    .cmdCfi  (busWdata[CFI_BIT]),
    .ptrStat (ptrStat),
    .cntIdle (cntIdle),
    .strobe  (strobe),
    .remapEn (remapEn),
    .errFlag (errFlag)
  );

  irc_datapath #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .busWr       (busWr),
    .busAddr     (busAddr),
    .busWdata    (busWdata),
    .busRdata    (busRdata),
    .strobe      (strobe),
    .irqAccept   (irqAccept),
    .irqComplete (irqComplete),
    .extMode     (extMode),
    .remapEn     (remapEn),
    .errFlag     (errFlag),
    .activePtr   (activePtr),
    .tableAddr   (tableAddr),
    .ptrStat     (ptrStat),
    .cfiStat     (cfiStat),
    .inflightCnt (inflightCnt),
    .cntIdle     (cntIdle),
    .compatPass  (compatPass)
  );
endmodule

// File: rtl/irc_chk.sv
module irc_chk
  import irc_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int PTR_W  = 32,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWr,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              irqAccept,
  input logic              irqComplete,
  input logic              remapEn,
  input logic [PTR_W-1:0]  activePtr,
  input logic [PTR_W-1:0]  tableAddr,
  input logic              ptrStat,
  input logic              errFlag,
  input logic [CNT_W-1:0]  inflightCnt
);
  logic cmdHit;
  assign cmdHit = busWr && (busAddr == ADDR_W'(CMD_OFF));

  // R2
  cmd_reads_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == ADDR_W'(CMD_OFF)) |-> (busRdata == '0));

  // R3
  boundary_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(remapEn) |-> $past((inflightCnt == '0) && !irqAccept));

  // R5
  ptr_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdHit && busWdata[PTR_BIT]) |=> (activePtr == $past(tableAddr)) && ptrStat);

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(cmdHit && busWdata[PTR_BIT]) |=> $stable(activePtr) && $stable(ptrStat));

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errFlag |=> errFlag);

  // R8
  en_needs_ptr_chk: assert property (@(posedge clk) disable iff (!rstN)
    remapEn |-> ptrStat);

  // R10
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((inflightCnt == '0) && irqComplete && !irqAccept) |=> (inflightCnt == '0));
endmodule

bind irq_remap_cmd_ctrl irc_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busWdata    (busWdata),
  .busRdata    (busRdata),
  .irqAccept   (irqAccept),
  .irqComplete (irqComplete),
  .remapEn     (remapEn),
  .activePtr   (activePtr),
  .tableAddr   (tableAddr),
  .ptrStat     (ptrStat),
  .errFlag     (errFlag),
  .inflightCnt (inflightCnt)
);

// File: tb/sim_irq_remap_cmd_ctrl.sv
`timescale 1ns/1ps
module sim_irq_remap_cmd_ctrl;
  localparam logic [7:0] A_CMD  = 8'h18;
  localparam logic [7:0] A_STAT = 8'h1C;
  localparam logic [7:0] A_TADR = 8'h20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWr = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqAccept = 1'b0;
  logic        irqComplete = 1'b0;
  logic        extMode = 1'b0;
  logic        remapEn;
  logic [31:0] activePtr;
  logic        compatPass;

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_remap_cmd_ctrl u0 (
    .clk(clk), .rstN(rstN), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .irqAccept(irqAccept),
    .irqComplete(irqComplete), .extMode(extMode), .remapEn(remapEn),
    .activePtr(activePtr), .compatPass(compatPass)
  );

  // vector: {cmd en, cmd ptr, cmd cfi, exp en, exp ptr, exp cfi, exp err}
  localparam logic [6:0] VEC [5] = '{
    7'b100_0001,
    7'b011_0111,
    7'b101_1111,
    7'b100_1101,
    7'b001_0111
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busWr = 1'b1; busAddr = a; busWdata = d;
    @(negedge clk);
    busWr = 1'b0; busWdata = '0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #0.5;
    d = busRdata;
  endtask

  task automatic pulse(input logic acc, input logic cmp);
    @(negedge clk);
    irqAccept = acc; irqComplete = cmp;
    @(negedge clk);
    irqAccept = 1'b0; irqComplete = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  function automatic logic [31:0] cmdWord(input logic en, input logic ptr, input logic cfi);
    logic [31:0] w;
    w = '0; w[25] = en; w[24] = ptr; w[23] = cfi;
    return w;
  endfunction

  function automatic logic [31:0] statWord(input logic [3:0] f);
    logic [31:0] w;
    w = '0; w[25] = f[3]; w[24] = f[2]; w[23] = f[1]; w[0] = f[0];
    return w;
  endfunction

  initial begin
    logic [31:0] rd;
    doReset();

    // R1 reset state
    busRead(A_STAT, rd);
    check("R1 status", rd, 32'h0);
    check("R1 remapEn", {31'b0, remapEn}, 32'h0);
    check("R1 activePtr", activePtr, 32'h0);
    check("R1 compatPass", {31'b0, compatPass}, 32'h1);

    // Vector table walk with no traffic (R2 R3 R5 R7 R8)
    busWrite(A_TADR, 32'hABCD_0000);
    for (int i = 0; i < 5; i++) begin
      busWrite(A_CMD, cmdWord(VEC[i][6], VEC[i][5], VEC[i][4]));
      @(negedge clk);
      busRead(A_STAT, rd);
      check($sformatf("R2 R3 R7 R8 vector %0d status", i), rd, statWord(VEC[i][3:0]));
      check($sformatf("R5 vector %0d pointer", i), activePtr,
            VEC[i][2] ? 32'hABCD_0000 : 32'h0);
    end
    busRead(A_CMD, rd);
    check("R2 command reads zero", rd, 32'h0);
    busRead(A_TADR, rd);
    check("R2 table address readback", rd, 32'hABCD_0000);

    // R8 enable together with pointer load in one write is accepted
    doReset();
    busWrite(A_TADR, 32'h1111_2000);
    busWrite(A_CMD, cmdWord(1'b1, 1'b1, 1'b1));
    check("R3 enable not before next edge", {31'b0, remapEn}, 32'h0);
    @(negedge clk);
    busRead(A_STAT, rd);
    check("R8 same-write enable status", rd, statWord(4'b1110));

    // R6 bit 24 clear leaves pointer
    busWrite(A_TADR, 32'h2222_3000);
    busWrite(A_CMD, cmdWord(1'b1, 1'b0, 1'b1));
    check("R6 pointer unchanged", activePtr, 32'h1111_2000);
    busWrite(A_CMD, cmdWord(1'b1, 1'b1, 1'b1));
    check("R5 pointer reload", activePtr, 32'h2222_3000);

    // R10 spurious completion at zero must not wrap; R3 drain
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    pulse(1'b1, 1'b0);
    busWrite(A_CMD, cmdWord(1'b0, 1'b0, 1'b1));
    repeat (3) @(negedge clk);
    check("R3 held while two in flight", {31'b0, remapEn}, 32'h1);
    pulse(1'b0, 1'b1);
    check("R10 held while one in flight", {31'b0, remapEn}, 32'h1);
    pulse(1'b0, 1'b1);
    check("R3 held at drain edge", {31'b0, remapEn}, 32'h1);
    @(negedge clk);
    busRead(A_STAT, rd);
    check("R3 disable after drain", rd, statWord(4'b0110));

    // R3 accept at zero count defers the change
    busWrite(A_CMD, cmdWord(1'b1, 1'b0, 1'b1));
    irqAccept = 1'b1;
    @(negedge clk);
    irqAccept = 1'b0;
    check("R3 deferred by accept", {31'b0, remapEn}, 32'h0);
    pulse(1'b0, 1'b1);
    check("R3 held at completion edge", {31'b0, remapEn}, 32'h0);
    @(negedge clk);
    check("R3 enable after accept drained", {31'b0, remapEn}, 32'h1);

    // R4 matching write cancels pending request
    pulse(1'b1, 1'b0);
    busWrite(A_CMD, cmdWord(1'b0, 1'b0, 1'b1));
    busWrite(A_CMD, cmdWord(1'b1, 1'b0, 1'b1));
    pulse(1'b0, 1'b1);
    repeat (2) @(negedge clk);
    check("R4 cancelled disable", {31'b0, remapEn}, 32'h1);

    // R9 compatibility decision
    check("R9 pass when on and policy 1", {31'b0, compatPass}, 32'h1);
    extMode = 1'b1;
    #0.5;
    check("R9 block in extended mode", {31'b0, compatPass}, 32'h0);
    extMode = 1'b0;
    busWrite(A_CMD, cmdWord(1'b1, 1'b0, 1'b0));
    check("R9 R7 block with policy 0", {31'b0, compatPass}, 32'h0);
    busWrite(A_CMD, cmdWord(1'b0, 1'b0, 1'b0));
    @(negedge clk);
    check("R9 pass when remap off", {31'b0, compatPass}, 32'h1);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      nRun++;
      nFail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule